// File: doc/BRIEF.md
# Reverse-Polish Expression Evaluator

This block runs arithmetic expressions written in postfix order directly on a small hardware stack held in registers. Tokens arrive one at a time over a valid/ready handshake. A token either pushes a signed operand or names one of four binary operators: add, subtract, multiply or divide. Each operator takes the two most recent entries and replaces them with one result. A terminating token then hands the single remaining entry out as the result of the expression.

Every token except a divide is consumed in a single cycle. A divide runs on a sequential divider and holds the input stalled until the quotient has been written back. Faults are reported as one-cycle flags in the cycle after the offending token: a push onto a full stack, an operator with too few operands, a division by zero, and a terminating token that finds anything other than exactly one entry. A host streams the postfix form of an expression, for example `a b c * + a d c * + e - /`, and then collects the result.

Top module: `rpn_eval`

## Requirements
- R1: A push token (kind code 0) stores `tok_data` as the new top entry and raises the stack depth by one. Operands are taken in push order.
- R2: Kind 1 adds, kind 2 subtracts and kind 3 multiplies. The entry second from the top is the left operand and the top entry is the right operand. The two entries are replaced by the result, which wraps to the low 16 bits in two's complement.
- R3: A push while the stack holds 8 entries raises `err_overflow` for one cycle, in the cycle after acceptance. The stack is left unchanged.
- R4: An operator (kinds 1 to 4) accepted with fewer than two entries raises `err_underflow` for one cycle and leaves the stack unchanged.
- R5: Kind 4 divides the second entry by the top entry, with the quotient truncated toward zero. -32768 / -1 gives -32768. `tok_ready` is low from the cycle after a divide is accepted until the quotient has been stored. For every other kind, `tok_ready` stays high.
- R6: A divide with a zero top entry raises `err_divzero` for one cycle, replaces both entries with 0 and does not stall.
- R7: An end token (kind 5) accepted with exactly one entry drives `res_valid` high for exactly one cycle, in the cycle after acceptance, with that entry on `res_data`, and empties the stack.
- R8: An end token accepted with zero entries or with two or more raises `err_depth` for one cycle, keeps `res_valid` low and empties the stack.
- R9: Kind codes 6 and 7 are consumed with no effect on the stack or on any output.
- R10: While reset is held, the stack is empty, `tok_ready` is high, and `res_valid` and all error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | Token offered |
| tok_ready | output | 1 | Token can be accepted this cycle |
| tok_kind | input | 3 | 0 push, 1 add, 2 sub, 3 mul, 4 div, 5 end, 6-7 no-op |
| tok_data | input | 16 | Signed operand for a push |
| res_valid | output | 1 | One-cycle pulse: result available |
| res_data | output | 16 | Signed expression result |
| err_overflow | output | 1 | Push onto a full stack |
| err_underflow | output | 1 | Operator lacking two operands |
| err_divzero | output | 1 | Divide by zero |
| err_depth | output | 1 | End token with a depth other than one |

## Verification
A nested expression with mixed operators checks that intermediate results are kept in their stack positions across a depth of four. Short subtract and divide expressions with operands of mixed sign separate the correct operand order and truncation toward zero from reversed operands or floor division. Wrapping cases (a multiply that exceeds 16 bits, an add of the largest positive value, and -32768 / -1) expose sign and width handling. After each fault, the expression is completed so that the result read at the port shows whether the rejected token changed the stack.

// File: rtl/rpn_pkg.sv
package rpn_pkg;
  typedef enum logic [2:0] {
    TK_PUSH = 3'd0,
    TK_ADD  = 3'd1,
    TK_SUB  = 3'd2,
    TK_MUL  = 3'd3,
    TK_DIV  = 3'd4,
    TK_END  = 3'd5,
    TK_NOP6 = 3'd6,
    TK_NOP7 = 3'd7
  } tok_e;

  typedef enum logic {
    ST_RUN = 1'b0,
    ST_DIV = 1'b1
  } ctl_e;
endpackage

// File: rtl/rpn_stack.sv
module rpn_stack #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic          reduce_en,
  input  logic          clear_en,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  top_q,
  output logic [W-1:0]  nxt_q,
  output logic [CW-1:0] depth_q
);
  logic [DEPTH-1:0][W-1:0] ent;
  logic [CW-1:0]           depth_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [W-1:0] val_q;
    logic         we;
    assign we = (push_en && depth_q == CW'(g)) ||
                (reduce_en && depth_q == CW'(g + 2));
    always_ff @(posedge clk) begin
      if (we) val_q <= wr_data;
    end
    assign ent[g] = val_q;
  end

  always_comb begin
    top_q = '0;
    nxt_q = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (depth_q == CW'(i + 1)) top_q = ent[i];
      if (depth_q == CW'(i + 2)) nxt_q = ent[i];
    end
  end

  always_comb begin
    depth_d = depth_q;
    if (clear_en)       depth_d = '0;
    else if (push_en)   depth_d = depth_q + CW'(1);
    else if (reduce_en) depth_d = depth_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) depth_q <= '0;
    else        depth_q <= depth_d;
  end
endmodule

// File: rtl/rpn_div.sv
module rpn_div #(
  parameter int W = 16,
  localparam int NW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot
);
  logic          busy_q, busy_d, done_q, done_d;
  logic [NW-1:0] cnt_q, cnt_d;
  logic          neg_q, neg_d;
  logic [W-1:0]  dvs_q, dvs_d, quo_q, quo_d;
  logic [W:0]    rem_q, rem_d, shifted;
  logic          data_en;

  assign shifted = {rem_q[W-1:0], quo_q[W-1]};

  always_comb begin
    busy_d  = busy_q;
    done_d  = 1'b0;
    cnt_d   = cnt_q;
    neg_d   = neg_q;
    dvs_d   = dvs_q;
    quo_d   = quo_q;
    rem_d   = rem_q;
    data_en = 1'b0;
    if (start) begin
      data_en = 1'b1;
      busy_d  = 1'b1;
      cnt_d   = NW'(W);
      neg_d   = dividend[W-1] ^ divisor[W-1];
      quo_d   = dividend[W-1] ? -dividend : dividend;
      dvs_d   = divisor[W-1] ? -divisor : divisor;
      rem_d   = '0;
    end else if (busy_q) begin
      data_en = 1'b1;
      if (shifted >= {1'b0, dvs_q}) begin
        rem_d = shifted - {1'b0, dvs_q};
        quo_d = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_d = shifted;
        quo_d = {quo_q[W-2:0], 1'b0};
      end
      cnt_d = cnt_q - NW'(1);
      if (cnt_q == NW'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      neg_q <= neg_d;
      dvs_q <= dvs_d;
      quo_q <= quo_d;
      rem_q <= rem_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign quot = neg_q ? -quo_q : quo_q;
endmodule

// File: rtl/rpn_eval.sv
module rpn_eval #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  output logic              tok_ready,
  input  logic [2:0]        tok_kind,
  input  logic [DATA_W-1:0] tok_data,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              err_overflow,
  output logic              err_underflow,
  output logic              err_divzero,
  output logic              err_depth
);
  import rpn_pkg::*;
  localparam int CW = $clog2(DEPTH + 2);

  ctl_e              state_q, state_d;
  logic [CW-1:0]     depth;
  logic [DATA_W-1:0] top, nxt, wr_data, quot, res_d;
  logic              push_en, reduce_en, clear_en, div_start, div_busy, div_done;
  logic              accept, has_two, is_full, is_one;
  logic              rv_d, ovf_d, udf_d, dz_d, ed_d;
  tok_e              kind;

  rpn_stack #(.W(DATA_W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .reduce_en(reduce_en),
    .clear_en(clear_en), .wr_data(wr_data), .top_q(top), .nxt_q(nxt),
    .depth_q(depth)
  );

  rpn_div #(.W(DATA_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .dividend(nxt),
    .divisor(top), .busy(div_busy), .done(div_done), .quot(quot)
  );

  assign kind      = tok_e'(tok_kind);
  assign tok_ready = (state_q == ST_RUN);
  assign accept    = tok_valid && tok_ready;
  assign has_two   = depth >= CW'(2);
  assign is_full   = depth == CW'(DEPTH);
  assign is_one    = depth == CW'(1);

  always_comb begin
    state_d   = state_q;
    push_en   = 1'b0;
    reduce_en = 1'b0;
    clear_en  = 1'b0;
    div_start = 1'b0;
    wr_data   = tok_data;
    rv_d      = 1'b0;
    res_d     = top;
    ovf_d     = 1'b0;
    udf_d     = 1'b0;
    dz_d      = 1'b0;
    ed_d      = 1'b0;
    if (state_q == ST_DIV) begin
      if (div_done) begin
        reduce_en = 1'b1;
        wr_data   = quot;
        state_d   = ST_RUN;
      end
    end else if (accept) begin
      case (kind)
        TK_PUSH: begin
          if (is_full) ovf_d   = 1'b1;
          else         push_en = 1'b1;
        end
        TK_ADD, TK_SUB, TK_MUL: begin
          if (!has_two) udf_d = 1'b1;
          else begin
            reduce_en = 1'b1;
            if (kind == TK_ADD)      wr_data = nxt + top;
            else if (kind == TK_SUB) wr_data = nxt - top;
            else                     wr_data = nxt * top;
          end
        end
        TK_DIV: begin
          if (!has_two) udf_d = 1'b1;
          else if (top == '0) begin
            dz_d      = 1'b1;
            reduce_en = 1'b1;
            wr_data   = '0;
          end else begin
            div_start = 1'b1;
            state_d   = ST_DIV;
          end
        end
        TK_END: begin
          clear_en = 1'b1;
          if (is_one) rv_d = 1'b1;
          else        ed_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_RUN;
      res_valid     <= 1'b0;
      err_overflow  <= 1'b0;
      err_underflow <= 1'b0;
      err_divzero   <= 1'b0;
      err_depth     <= 1'b0;
    end else begin
      state_q       <= state_d;
      res_valid     <= rv_d;
      err_overflow  <= ovf_d;
      err_underflow <= udf_d;
      err_divzero   <= dz_d;
      err_depth     <= ed_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rv_d) res_data <= res_d;
  end
endmodule

// File: rtl/rpn_eval_chk.sv
module rpn_eval_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int CW    = $clog2(DEPTH + 2)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tok_valid,
  input logic          tok_ready,
  input logic [2:0]    tok_kind,
  input logic [CW-1:0] depth,
  input logic          res_valid,
  input logic          err_overflow,
  input logic          err_underflow,
  input logic          err_divzero,
  input logic          err_depth
);
  assert_push_grows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_ready && tok_kind == 3'd0 && depth < CW'(DEPTH))
    |=> depth == $past(depth) + CW'(1));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |-> depth == $past(depth));

  always @(posedge clk) begin
    if (rst_n) assert_depth_bound_R3: assert (depth <= CW'(DEPTH));
  end

  assert_underflow_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |-> depth == $past(depth));

  assert_div_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tok_ready) |-> ($past(tok_valid) && $past(tok_kind) == 3'd4));

  assert_divzero_pops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_divzero |-> depth == $past(depth) - CW'(1));

  assert_result_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> depth == '0);

  assert_bad_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_depth |-> (depth == '0 && !res_valid));

  assert_one_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_valid, err_overflow, err_underflow, err_divzero, err_depth}));
endmodule

bind rpn_eval rpn_eval_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ready(tok_ready),
  .tok_kind(tok_kind), .depth(depth), .res_valid(res_valid),
  .err_overflow(err_overflow), .err_underflow(err_underflow),
  .err_divzero(err_divzero), .err_depth(err_depth)
);

// File: tb/rpn_eval_tb.sv
module rpn_eval_tb;
  localparam logic [2:0] K_PUSH = 3'd0, K_ADD = 3'd1, K_SUB = 3'd2,
                         K_MUL = 3'd3, K_DIV = 3'd4, K_END = 3'd5;
  localparam int NROW = 38;

  typedef struct packed {
    logic [2:0]  k;
    logic [15:0] d;
    logic [15:0] e;
  } row_t;

  // R1 R2 R5: expressions with expected results on the end rows
  localparam row_t TBL [NROW] = '{
    '{K_PUSH, 16'd7, 16'd0}, '{K_PUSH, 16'd3, 16'd0}, '{K_PUSH, 16'd4, 16'd0},
    '{K_MUL, 16'd0, 16'd0},  '{K_ADD, 16'd0, 16'd0},  '{K_PUSH, 16'd7, 16'd0},
    '{K_PUSH, 16'd2, 16'd0}, '{K_PUSH, 16'd4, 16'd0}, '{K_MUL, 16'd0, 16'd0},
    '{K_ADD, 16'd0, 16'd0},  '{K_PUSH, 16'd1, 16'd0}, '{K_SUB, 16'd0, 16'd0},
    '{K_DIV, 16'd0, 16'd0},  '{K_END, 16'd0, 16'd1},
    '{K_PUSH, 16'd10, 16'd0}, '{K_PUSH, 16'd3, 16'd0}, '{K_SUB, 16'd0, 16'd0},
    '{K_END, 16'd0, 16'd7},
    '{K_PUSH, 16'hFFF9, 16'd0}, '{K_PUSH, 16'd2, 16'd0}, '{K_DIV, 16'd0, 16'd0},
    '{K_END, 16'd0, 16'hFFFD},
    '{K_PUSH, 16'd7, 16'd0}, '{K_PUSH, 16'hFFFE, 16'd0}, '{K_DIV, 16'd0, 16'd0},
    '{K_END, 16'd0, 16'hFFFD},
    '{K_PUSH, 16'd300, 16'd0}, '{K_PUSH, 16'd300, 16'd0}, '{K_MUL, 16'd0, 16'd0},
    '{K_END, 16'd0, 16'd24464},
    '{K_PUSH, 16'h7FFF, 16'd0}, '{K_PUSH, 16'd1, 16'd0}, '{K_ADD, 16'd0, 16'd0},
    '{K_END, 16'd0, 16'h8000},
    '{K_PUSH, 16'h8000, 16'd0}, '{K_PUSH, 16'hFFFF, 16'd0}, '{K_DIV, 16'd0, 16'd0},
    '{K_END, 16'd0, 16'h8000}
  };

  logic        clk = 1'b0;
  logic        rst_n, tok_valid, tok_ready, res_valid;
  logic [2:0]  tok_kind;
  logic [15:0] tok_data, res_data;
  logic        err_overflow, err_underflow, err_divzero, err_depth;
  logic [3:0]  flags;
  int          n_chk = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  rpn_eval u_dut (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ready(tok_ready),
    .tok_kind(tok_kind), .tok_data(tok_data), .res_valid(res_valid),
    .res_data(res_data), .err_overflow(err_overflow),
    .err_underflow(err_underflow), .err_divzero(err_divzero),
    .err_depth(err_depth)
  );

  assign flags = {err_overflow, err_underflow, err_divzero, err_depth};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] k, input logic [15:0] d);
    @(negedge clk);
    while (!tok_ready) @(negedge clk);
    tok_valid = 1'b1;
    tok_kind  = k;
    tok_data  = d;
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tok_valid = 1'b0; tok_kind = 3'd0; tok_data = 16'd0;
    repeat (3) @(negedge clk);
    check("R10 ready in reset", 32'(tok_ready), 32'd1);
    check("R10 outputs low in reset", {27'd0, res_valid, flags}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NROW; i++) begin
      send(TBL[i].k, TBL[i].d);
      if (TBL[i].k == K_END) begin
        check("R7 result valid", 32'(res_valid), 32'd1);
        check("R2 R5 result value", 32'(res_data), 32'(TBL[i].e));
      end else begin
        check("R1 R2 no error flag", 32'(flags), 32'd0);
        if (TBL[i].k == K_DIV) check("R5 ready low during divide", 32'(tok_ready), 32'd0);
        else                   check("R5 ready high", 32'(tok_ready), 32'd1);
      end
    end

    // R3 overflow: ninth push rejected, sum shows it was not stored
    for (int v = 1; v <= 8; v++) send(K_PUSH, 16'(v));
    send(K_PUSH, 16'd99);
    check("R3 overflow flag", 32'(err_overflow), 32'd1);
    for (int j = 0; j < 7; j++) send(K_ADD, 16'd0);
    send(K_END, 16'd0);
    check("R3 stack unchanged after overflow", 32'(res_data), 32'd36);

    // R4 underflow
    send(K_ADD, 16'd0);
    check("R4 underflow on empty", 32'(err_underflow), 32'd1);
    send(K_PUSH, 16'd5);
    send(K_SUB, 16'd0);
    check("R4 underflow with one entry", 32'(err_underflow), 32'd1);
    send(K_END, 16'd0);
    check("R4 entry kept", {15'd0, res_valid, res_data}, {15'd0, 1'b1, 16'd5});

    // R6 divide by zero
    send(K_PUSH, 16'd9);
    send(K_PUSH, 16'd0);
    send(K_DIV, 16'd0);
    check("R6 divzero flag and no stall", {30'd0, err_divzero, tok_ready}, 32'd3);
    send(K_END, 16'd0);
    check("R6 zero pushed", {15'd0, res_valid, res_data}, {15'd0, 1'b1, 16'd0});

    // R8 bad depth at end
    send(K_PUSH, 16'd1);
    send(K_PUSH, 16'd2);
    send(K_END, 16'd0);
    check("R8 depth two", {30'd0, err_depth, res_valid}, 32'd2);
    send(K_END, 16'd0);
    check("R8 empty after clear", {30'd0, err_depth, res_valid}, 32'd2);
    send(K_PUSH, 16'd4);
    send(K_END, 16'd0);
    check("R8 fresh expression", 32'(res_data), 32'd4);
    @(negedge clk);
    check("R7 result pulse one cycle", 32'(res_valid), 32'd0);

    // R9 reserved codes
    send(K_PUSH, 16'd6);
    send(3'd6, 16'd77);
    check("R9 code 6 no effect", {27'd0, res_valid, flags}, 32'd0);
    send(3'd7, 16'd88);
    check("R9 code 7 no effect", {27'd0, res_valid, flags}, 32'd0);
    send(K_END, 16'd0);
    check("R9 stack kept", {15'd0, res_valid, res_data}, {15'd0, 1'b1, 16'd6});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule